// File: doc/BRIEF.md
# Week-Long Release Timer

The block counts seconds on a decimal counter built from cascaded BCD digit stages, advanced by a one-cycle tick enable that arrives once per second. It only counts after it has been armed. When the count equals a programmed target (604800 seconds, one week, by default), the block stops counting and fires a release pulse. The pulse width is a count of system clocks and does not depend on the tick. After that single pulse it raises a done flag, and it stays quiet until a clear.

The target match is taken from registered digits and passes through a register, so the one-shot never sees a partial match while digits ripple. A synchronous clear input returns the timer to idle. It also stops a pulse that is in progress. The BCD digits are exposed so that the count can be watched. The tick period is set by the source of the tick, and the pulse length is a parameter, so short values can be used in simulation.

Top module: `long_delay_timer`

## Requirements
- R1: While rst_ni is low, digits_o is all zero and release_o and done_o are low.
- R2: Ticks are ignored until arm_i has been seen high on a clock edge. Arming stays in effect until a clear or a reset.
- R3: Each accepted tick adds one to the count. Digit k sits at digits_o[4k+3:4k], and digit 0 is the units digit. A digit goes from 9 to 0 and increments the next digit only on that rollover. digits_o changes only on an edge where tick_i was high.
- R4: Once the digits equal TARGET, counting halts and further ticks leave digits_o unchanged until a clear.
- R5: release_o rises on the second clock edge after the edge at which the digits first equal TARGET. It then stays high for exactly PULSE_CYCLES clock cycles.
- R6: Each run produces exactly one pulse. done_o rises on the edge where release_o falls, and it stays high, with release_o low, until a clear.
- R7: A clear_i high on an edge zeroes the digits, disarms the timer, drops done_o and ends any pulse in progress. No pulse follows from the count that was cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle enable per second |
| clear_i | input | 1 | Synchronous manual clear |
| arm_i | input | 1 | Start counting |
| release_o | output | 1 | Release pulse |
| done_o | output | 1 | Release has finished |
| digits_o | output | 4*NUM_DIGITS | BCD count, units digit in the low nibble |

## Verification
The count is walked through a table of tick totals. The totals are chosen at every rollover depth: 9 to 10, 99 to 100, 999 to 1000, and the value one below target. These points separate a correct carry chain from one that carries early, late or into the wrong digit. The terminal tick checks the latency to the pulse edge and the exact pulse width. Extra ticks after the pulse show that the count halts and no second pulse appears. Ticks before arming and a clear in the middle of a pulse check the gating at both ends of a run.

// File: rtl/ldt_pkg.sv
package ldt_pkg;
  // BCD encoding of v, 16 digits, units in the low nibble
  function automatic logic [63:0] to_bcd(input int unsigned v);
    logic [63:0] r;
    int unsigned t;
    r = '0;
    t = v;
    for (int i = 0; i < 16; i++) begin
      r[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction
endpackage

// File: rtl/ldt_decade.sv
module ldt_decade (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       inc_i,
  output logic [3:0] digit_o
);
  logic [3:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            q <= '0;
    else if (clr_i)         q <= '0;
    else if (inc_i)         q <= (q == 4'd9) ? 4'd0 : q + 4'd1;
  end

  assign digit_o = q;
endmodule

// File: rtl/ldt_match.sv
module ldt_match #(
  parameter int unsigned DW = 24,
  parameter logic [DW-1:0] TGT = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [DW-1:0] digits_i,
  output logic          at_tgt_o,
  output logic          match_q_o
);
  assign at_tgt_o = (digits_i == TGT);

  // registered so the one-shot sees no ripple
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      match_q_o <= 1'b0;
    else if (clr_i)   match_q_o <= 1'b0;
    else              match_q_o <= at_tgt_o;
  end
endmodule

// File: rtl/ldt_oneshot.sv
module ldt_oneshot #(
  parameter int unsigned PULSE_CYCLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic trig_i,
  output logic pulse_o,
  output logic done_o
);
  localparam int unsigned CW = (PULSE_CYCLES < 2) ? 1 : $clog2(PULSE_CYCLES);

  logic          trig_d;
  logic          active;
  logic [CW-1:0] cnt;
  logic          fire;

  assign fire = trig_i & ~trig_d & ~active & ~done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_d <= 1'b0;
      active <= 1'b0;
      done_o <= 1'b0;
      cnt    <= '0;
    end else if (clr_i) begin
      trig_d <= 1'b0;
      active <= 1'b0;
      done_o <= 1'b0;
      cnt    <= '0;
    end else begin
      trig_d <= trig_i;
      if (fire) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active) begin
        if (cnt == CW'(PULSE_CYCLES - 1)) begin
          active <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign pulse_o = active;
endmodule

// File: rtl/long_delay_timer.sv
module long_delay_timer #(
  parameter int unsigned NUM_DIGITS   = 6,
  parameter int unsigned TARGET       = 604800,
  parameter int unsigned PULSE_CYCLES = 100
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    clear_i,
  input  logic                    arm_i,
  output logic                    release_o,
  output logic                    done_o,
  output logic [4*NUM_DIGITS-1:0] digits_o
);
  localparam int unsigned DW = 4 * NUM_DIGITS;
  localparam logic [63:0] TGT_ALL = ldt_pkg::to_bcd(TARGET);
  localparam logic [DW-1:0] TGT_BCD = TGT_ALL[DW-1:0];

  logic                  run_q;
  logic                  at_tgt;
  logic                  match_q;
  logic [NUM_DIGITS-1:0] inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (clear_i) run_q <= 1'b0;
    else if (arm_i)   run_q <= 1'b1;
  end

  assign inc[0] = tick_i & run_q & ~at_tgt & ~done_o;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dec
    ldt_decade u_dec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clear_i),
      .inc_i  (inc[k]),
      .digit_o(digits_o[k*4 +: 4])
    );
    if (k < NUM_DIGITS - 1) begin : g_carry
      assign inc[k+1] = inc[k] & (digits_o[k*4 +: 4] == 4'd9);
    end
  end

  ldt_match #(.DW(DW), .TGT(TGT_BCD)) u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clear_i),
    .digits_i (digits_o),
    .at_tgt_o (at_tgt),
    .match_q_o(match_q)
  );

  ldt_oneshot #(.PULSE_CYCLES(PULSE_CYCLES)) u_shot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clear_i),
    .trig_i (match_q),
    .pulse_o(release_o),
    .done_o (done_o)
  );
endmodule

// File: rtl/long_delay_timer_chk.sv
module long_delay_timer_chk #(
  parameter int unsigned NUM_DIGITS   = 6,
  parameter int unsigned TARGET       = 604800,
  parameter int unsigned PULSE_CYCLES = 100
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tick_i,
  input logic                    clear_i,
  input logic                    release_o,
  input logic                    done_o,
  input logic [4*NUM_DIGITS-1:0] digits_o
);
  localparam logic [63:0] TB_ALL = ldt_pkg::to_bcd(TARGET);
  localparam logic [4*NUM_DIGITS-1:0] TB = TB_ALL[4*NUM_DIGITS-1:0];

  // R3
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i) |=> $stable(digits_o));
  // R4
  halt_at_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digits_o == TB && !clear_i) |=> $stable(digits_o));
  // R5
  pulse_on_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(release_o) |-> (digits_o == TB));
  // R6
  done_after_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(release_o) && !$past(clear_i) |-> done_o);
  // R6
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !release_o);
  // R6
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clear_i) |=> done_o);
  // R7
  clear_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (digits_o == '0 && !release_o && !done_o));
endmodule

bind long_delay_timer long_delay_timer_chk #(
  .NUM_DIGITS(NUM_DIGITS), .TARGET(TARGET), .PULSE_CYCLES(PULSE_CYCLES)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .clear_i(clear_i),
  .release_o(release_o), .done_o(done_o), .digits_o(digits_o)
);

// File: tb/test_long_delay_timer.sv
module test_long_delay_timer;
  localparam int unsigned ND = 6;
  localparam int unsigned TGT = 1205;
  localparam int unsigned PW = 5;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 10;
  localparam int unsigned VEC [NV] = '{0, 1, 9, 10, 11, 99, 100, 999, 1000, 1204};

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, clear_i = 1'b0, arm_i = 1'b0;
  logic release_o, done_o;
  logic [4*ND-1:0] digits_o;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  long_delay_timer #(.NUM_DIGITS(ND), .TARGET(TGT), .PULSE_CYCLES(PW)) i_long_delay_timer (
    .clk_i, .rst_ni, .tick_i, .clear_i, .arm_i, .release_o, .done_o, .digits_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [4*ND-1:0] exp_bcd(input int unsigned v);
    logic [4*ND-1:0] r;
    for (int i = 0; i < ND; i++) begin
      r[i*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk_i) tick_i = 1'b1;
    @(negedge clk_i) tick_i = 1'b0;
  endtask

  task automatic pulse_in(ref logic s);
    @(negedge clk_i) s = 1'b1;
    @(negedge clk_i) s = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    summary();
  end

  initial begin
    int unsigned cnt;
    int highs, first, rises;
    logic prev;
    repeat (2) @(negedge clk_i);
    // R1
    chk(digits_o == '0 && !release_o && !done_o, "R1 reset", {release_o, done_o, digits_o}, 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R2: ticks before arm are ignored
    repeat (3) tick_once();
    chk(digits_o == '0, "R2 unarmed", digits_o, 0);
    pulse_in(arm_i);

    // R3: table walk
    cnt = 0;
    for (int i = 0; i < NV; i++) begin
      while (cnt < VEC[i]) begin tick_once(); cnt++; end
      chk(digits_o == exp_bcd(VEC[i]), "R3 count", digits_o, exp_bcd(VEC[i]));
    end

    // R5: terminal tick, latency and width
    tick_once();
    chk(digits_o == exp_bcd(TGT) && !release_o, "R5 at target", {release_o, digits_o}, exp_bcd(TGT));
    @(negedge clk_i);
    chk(!release_o, "R5 latency", release_o, 0);
    highs = 0; first = -1; rises = 0; prev = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk_i);
      if (release_o) begin highs++; if (first < 0) first = c; end
      if (release_o && !prev) rises++;
      prev = release_o;
    end
    chk(first == 0, "R5 start", first, 0);
    chk(highs == PW, "R5 width", highs, PW);
    chk(rises == 1, "R6 single", rises, 1);
    chk(done_o, "R6 done", done_o, 1);

    // R4: ticks after done change nothing
    repeat (5) tick_once();
    chk(digits_o == exp_bcd(TGT), "R4 halt", digits_o, exp_bcd(TGT));
    chk(done_o && !release_o, "R6 hold", {done_o, release_o}, 2);

    // R7: clear, rerun, clear mid pulse
    pulse_in(clear_i);
    chk(digits_o == '0 && !done_o, "R7 clear", {done_o, digits_o}, 0);
    tick_once();
    chk(digits_o == '0, "R7 disarm", digits_o, 0);
    pulse_in(arm_i);
    for (int i = 0; i < TGT; i++) tick_once();
    repeat (2) @(negedge clk_i);
    chk(release_o, "R5 rerun", release_o, 1);
    pulse_in(clear_i);
    chk(!release_o && !done_o && digits_o == '0, "R7 cancel", {release_o, done_o, digits_o}, 0);
    highs = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk_i);
      if (release_o || done_o) highs++;
    end
    chk(highs == 0, "R7 no pulse", highs, 0);
    summary();
  end
endmodule